// File: doc/BRIEF.md
# Two-Layer Alpha Pixel Blender

This block mixes a foreground pixel over a background pixel. Both inputs and the result are 8-bit-per-channel ARGB words. It first forms the alpha product of the two layers, floored after division by 255, and from it a combined output alpha. Each of the red, green and blue channels is then the alpha-weighted sum of the two layers, divided by the output alpha and rounded down. The division is a restoring divider with one pipeline stage per quotient bit. The block therefore accepts one pixel pair per cycle and returns results in order after a fixed number of cycles.

The block has no configuration registers. A 3-bit operating mode travels with each pixel pair. Only the blend mode code runs the blend arithmetic. Every other code sends the foreground pixel to the output unchanged, and the pair takes the same path and latency as a blended one. A single stream handshake sits on each side. When the output is not taken, the whole pipeline stops and holds its contents.

Top module: `alpha_blend_pipe`

## Requirements
- R1: In blend mode (mode_i = 3'b010) the output alpha (bits 31:24) is aF + aB − M, where M = floor(aF·aB/255), aF = fg_i[31:24] and aB = bg_i[31:24].
- R2: In blend mode each colour channel (red 23:16, green 15:8, blue 7:0) equals floor((Cf·aF + Cb·aB − Cb·M) / aOUT), where Cf and Cb are the same-position channels of fg_i and bg_i.
- R3: In blend mode, when the output alpha is 0, all three colour channels of the result are 0.
- R4: For any mode code other than 3'b010, the result equals fg_i bit for bit, and bg_i has no effect on it.
- R5: The mode is captured together with its pixel pair. Pairs with different modes may follow each other back to back, and each pair is processed under its own mode.
- R6: A pair accepted at a clock edge (in_valid_i and in_ready_o both high) is presented on out_valid_o/pix_o after the 17th following edge, provided out_ready_i stays high.
- R7: While out_valid_o is high and out_ready_i is low, pix_o and out_valid_o hold and in_ready_o is low. Every accepted pair leaves exactly once, in acceptance order.
- R8: While rst_ni is low, out_valid_o is 0 and in_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operating mode of the offered pair; 3'b010 blends |
| in_valid_i | input | 1 | Input pair valid |
| in_ready_o | output | 1 | Block can take a pair this cycle |
| fg_i | input | 32 | Foreground ARGB (A 31:24, R 23:16, G 15:8, B 7:0) |
| bg_i | input | 32 | Background ARGB, same layout |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes the result |
| pix_o | output | 32 | Result ARGB, same layout |

## Verification
The bench sweeps every one of the 65,536 alpha pairs with varied colours and compares the results against integer arithmetic. This covers the floor of the alpha product at both ends. A design that rounded to nearest instead of down, or that divided by 256, would be off by one on many of these pairs. Both alphas at 0 is the case that would feed a divisor of zero: a design without a guard there would return all-ones colours instead of black. Mode changes on every pixel would expose any mode that is not carried with its own data. Random output stalls would show a result that changes while stalled, or a pixel that is lost or sent twice.

// File: rtl/alpha_blend_pkg.sv
package alpha_blend_pkg;
  localparam int unsigned CH_W  = 8;
  localparam int unsigned N_CH  = 3;
  localparam int unsigned NUM_W = 2 * CH_W + 1;
  localparam int unsigned CMAX  = (1 << CH_W) - 1;

  typedef logic [CH_W-1:0]  chan_t;
  typedef logic [NUM_W-1:0] num_t;

  typedef struct packed {
    chan_t a;
    chan_t r;
    chan_t g;
    chan_t b;
  } argb_t;
endpackage

// File: rtl/ab_alpha_stage.sv
module ab_alpha_stage
  import alpha_blend_pkg::*;
(
  input  logic  blend_i,
  input  argb_t fg_i,
  input  argb_t bg_i,
  output chan_t aout_o,
  output chan_t den_o,
  output logic  zero_o,
  output num_t  num_o [N_CH]
);
  logic [2*CH_W-1:0] prod, mult_w;
  logic [CH_W:0]     asum;
  chan_t             mult, bg_w;
  chan_t             fgc [N_CH];
  chan_t             bgc [N_CH];

  // channel index 2 = red, 1 = green, 0 = blue
  assign fgc[2] = fg_i.r;
  assign fgc[1] = fg_i.g;
  assign fgc[0] = fg_i.b;
  assign bgc[2] = bg_i.r;
  assign bgc[1] = bg_i.g;
  assign bgc[0] = bg_i.b;

  assign prod   = (2*CH_W)'(fg_i.a) * (2*CH_W)'(bg_i.a);
  assign mult_w = prod / (2*CH_W)'(CMAX);
  assign mult   = mult_w[CH_W-1:0];
  assign asum   = (CH_W+1)'(fg_i.a) + (CH_W+1)'(bg_i.a) - (CH_W+1)'(mult);
  // mult never exceeds either alpha, so this stays non-negative
  assign bg_w   = bg_i.a - mult;

  always_comb begin
    if (blend_i) begin
      aout_o = asum[CH_W-1:0];
      den_o  = asum[CH_W-1:0];
      zero_o = (asum == '0);
      for (int c = 0; c < N_CH; c++)
        num_o[c] = NUM_W'(fgc[c]) * NUM_W'(fg_i.a) + NUM_W'(bgc[c]) * NUM_W'(bg_w);
    end else begin
      // pass-through rides the divider as a division by one
      aout_o = fg_i.a;
      den_o  = chan_t'(1);
      zero_o = 1'b0;
      for (int c = 0; c < N_CH; c++)
        num_o[c] = NUM_W'(fgc[c]);
    end
  end
endmodule

// File: rtl/ab_div_step.sv
module ab_div_step
  import alpha_blend_pkg::*;
(
  input  chan_t den_i,
  input  chan_t rem_i,
  input  num_t  num_i,
  output chan_t rem_o,
  output num_t  num_o
);
  logic [CH_W:0] trial, diff;

  assign trial = {rem_i, num_i[NUM_W-1]};
  assign diff  = trial - {1'b0, den_i};

  // quotient bits shift in at the bottom as dividend bits leave the top
  always_comb begin
    if (trial >= {1'b0, den_i}) begin
      rem_o = diff[CH_W-1:0];
      num_o = {num_i[NUM_W-2:0], 1'b1};
    end else begin
      rem_o = trial[CH_W-1:0];
      num_o = {num_i[NUM_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/alpha_blend_pipe.sv
module alpha_blend_pipe
  import alpha_blend_pkg::*;
#(
  parameter int unsigned         MODE_W     = 3,
  parameter logic [MODE_W-1:0]   BLEND_MODE = MODE_W'(2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [4*CH_W-1:0] fg_i,
  input  logic [4*CH_W-1:0] bg_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [4*CH_W-1:0] pix_o
);
  localparam int unsigned DEPTH = NUM_W + 1;
  localparam int unsigned LAST  = DEPTH - 1;

  logic  vld_q   [DEPTH];
  logic  blend_q [DEPTH];
  logic  zero_q  [DEPTH];
  chan_t aout_q  [DEPTH];
  chan_t den_q   [DEPTH];
  chan_t rem_q   [DEPTH][N_CH];
  num_t  num_q   [DEPTH][N_CH];

  chan_t rem_d [DEPTH][N_CH];
  num_t  num_d [DEPTH][N_CH];

  logic  advance, blend_in, zero_in;
  chan_t aout_in, den_in;
  num_t  num_in [N_CH];

  assign advance    = !vld_q[LAST] || out_ready_i;
  assign in_ready_o = advance;
  assign blend_in   = (mode_i == BLEND_MODE);

  ab_alpha_stage u_alpha (
    .blend_i (blend_in),
    .fg_i    (argb_t'(fg_i)),
    .bg_i    (argb_t'(bg_i)),
    .aout_o  (aout_in),
    .den_o   (den_in),
    .zero_o  (zero_in),
    .num_o   (num_in)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_in
    assign rem_d[0][c] = '0;
    assign num_d[0][c] = num_in[c];
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      ab_div_step u_step (
        .den_i (den_q[k-1]),
        .rem_i (rem_q[k-1][c]),
        .num_i (num_q[k-1][c]),
        .rem_o (rem_d[k][c]),
        .num_o (num_d[k][c])
      );

      assert_rem_lt_den_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_q[k] && !zero_q[k]) |-> (rem_q[k][c] < den_q[k]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) begin
        vld_q[k]   <= 1'b0;
        blend_q[k] <= 1'b0;
        zero_q[k]  <= 1'b0;
        aout_q[k]  <= '0;
        den_q[k]   <= '0;
        for (int c = 0; c < N_CH; c++) begin
          rem_q[k][c] <= '0;
          num_q[k][c] <= '0;
        end
      end
    end else if (advance) begin
      vld_q[0]   <= in_valid_i;
      blend_q[0] <= blend_in;
      zero_q[0]  <= zero_in;
      aout_q[0]  <= aout_in;
      den_q[0]   <= den_in;
      for (int k = 1; k < DEPTH; k++) begin
        vld_q[k]   <= vld_q[k-1];
        blend_q[k] <= blend_q[k-1];
        zero_q[k]  <= zero_q[k-1];
        aout_q[k]  <= aout_q[k-1];
        den_q[k]   <= den_q[k-1];
      end
      for (int k = 0; k < DEPTH; k++)
        for (int c = 0; c < N_CH; c++) begin
          rem_q[k][c] <= rem_d[k][c];
          num_q[k][c] <= num_d[k][c];
        end
    end
  end

  chan_t res_c [N_CH];
  argb_t res;

  always_comb begin
    for (int c = 0; c < N_CH; c++) begin
      if (zero_q[LAST])                         res_c[c] = '0;
      else if (num_q[LAST][c] > NUM_W'(CMAX))   res_c[c] = chan_t'(CMAX);
      else                                      res_c[c] = num_q[LAST][c][CH_W-1:0];
    end
    res.a = aout_q[LAST];
    res.r = res_c[2];
    res.g = res_c[1];
    res.b = res_c[0];
  end

  assign pix_o       = res;
  assign out_valid_o = vld_q[LAST];

  for (genvar c = 0; c < N_CH; c++) begin : g_bound
    // weighted sum never exceeds full scale times output alpha
    assert_num_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_q[0] && blend_q[0]) |-> (num_q[0][c] <= NUM_W'(CMAX) * NUM_W'(den_q[0])));
  end

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(pix_o)));

  assert_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  assert_zero_alpha_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q[LAST] && blend_q[LAST] && aout_q[LAST] == '0) |-> (pix_o[3*CH_W-1:0] == '0));
endmodule

// File: tb/alpha_blend_pipe_tb.sv
module alpha_blend_pipe_tb;
  localparam logic [2:0] BLEND = 3'b010;
  localparam longint     LAT   = 18; // negedge samples from acceptance to delivery (17 edges + 1)
  localparam longint     WDOG  = 190000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  mode = '0;
  logic        in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [31:0] fg = '0, bg = '0, pix;

  always #5 clk = ~clk;

  alpha_blend_pipe u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .fg_i(fg), .bg_i(bg), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .pix_o(pix)
  );

  int          checks = 0, errors = 0;
  longint      cyc = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  longint      t_q   [$];
  bit          lat_chk = 0, stall_en = 0, stall_prev = 0;
  logic [31:0] held;
  logic [2:0]  prev_mode = BLEND;
  int unsigned seed = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    out_ready = stall_en ? ((cyc % 5) != 0 && (cyc % 7) != 3) : 1'b1;
  end

  function automatic int unsigned rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic logic [31:0] ref_pix(logic [2:0] m, logic [31:0] f, logic [31:0] b);
    int af, ab, mm, ao, cf, cb;
    logic [31:0] r;
    if (m != BLEND) return f;
    af = f[31:24]; ab = b[31:24];
    mm = (af * ab) / 255;
    ao = af + ab - mm;
    r[31:24] = ao[7:0];
    for (int c = 0; c < 3; c++) begin
      cf = f[c*8 +: 8]; cb = b[c*8 +: 8];
      r[c*8 +: 8] = (ao == 0) ? 8'd0 : 8'((cf * af + cb * ab - cb * mm) / ao);
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic send(logic [2:0] m, logic [31:0] f, logic [31:0] b);
    string t;
    logic [31:0] e;
    @(posedge clk); #1;
    in_valid = 1'b1; mode = m; fg = f; bg = b;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    e = ref_pix(m, f, b);
    if (m != prev_mode)        t = "R5";
    else if (m != BLEND)       t = "R4";
    else if (e[31:24] == 8'd0) t = "R3";
    else                       t = "R2";
    prev_mode = m;
    exp_q.push_back(e); tag_q.push_back(t); t_q.push_back(cyc);
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; in_valid = 1'b0; end
  endtask

  task automatic drain();
    stall_en = 0;
    idle(1);
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(posedge clk);
    check(exp_q.size() == 0, "R7", "pending after drain", 32'(exp_q.size()), 32'd0);
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (stall_prev)
        check(out_valid && pix == held, "R7", "held output", pix, held);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected output", pix, 32'd0);
        end else begin
          logic [31:0] e;
          string t;
          longint t0;
          e = exp_q.pop_front(); t = tag_q.pop_front(); t0 = t_q.pop_front();
          if (t == "R2" || t == "R3")
            check(pix[31:24] == e[31:24], "R1", "alpha", pix, e);
          check(pix == e, t, "pixel", pix, e);
          if (lat_chk)
            check(cyc - t0 == LAT, "R6", "latency", 32'(cyc - t0), 32'(LAT));
        end
      end else if (out_valid) begin
        check(!in_ready, "R7", "in_ready under stall", 32'(in_ready), 32'd0);
      end
      stall_prev = out_valid && !out_ready;
      held       = pix;
    end
  end

  always @(posedge clk) begin
    if (cyc > WDOG) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, WDOG);
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R8", "out_valid in reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R8", "in_ready in reset", 32'(in_ready), 32'd1);
    rst_ni = 1'b1;

    // R1 R2 R3 R6: every alpha pair, no stalls
    lat_chk = 1;
    for (int af = 0; af < 256; af++)
      for (int ab = 0; ab < 256; ab++) begin
        logic [23:0] cf, cb;
        cf = ((af + ab) % 7 == 0) ? 24'hFFFFFF : 24'(rnd());
        cb = ((af ^ ab) % 5 == 0) ? 24'hFFFFFF : 24'(rnd());
        send(BLEND, {8'(af), cf}, {8'(ab), cb});
      end
    drain();
    lat_chk = 0;

    // R3 R7: alpha and colour extremes under back-pressure
    stall_en = 1;
    begin
      logic [7:0]  al [4] = '{8'd0, 8'd1, 8'd254, 8'd255};
      logic [23:0] co [3] = '{24'h000000, 24'hFFFFFF, 24'h80FF01};
      foreach (al[i]) foreach (al[j]) foreach (co[p]) foreach (co[q])
        send(BLEND, {al[i], co[p]}, {al[j], co[q]});
    end

    // R4: every non-blend mode passes the foreground through
    for (int m = 0; m < 8; m++)
      if (3'(m) != BLEND)
        for (int i = 0; i < 20; i++) send(3'(m), rnd(), rnd());

    // R5: mode alternates on every pair
    for (int i = 0; i < 200; i++)
      send((i % 2) ? BLEND : 3'b101, rnd(), rnd());

    // mixed traffic with input gaps and stalls
    for (int i = 0; i < 2000; i++) begin
      send((rnd() % 4 != 0) ? BLEND : 3'(rnd()), rnd(), rnd());
      if (rnd() % 6 == 0) idle(1 + int'(rnd() % 3));
    end
    drain();
    summary();
  end
endmodule